// File: doc/BRIEF.md
# Register-List Multiple Transfer Sequencer

This block carries out a multi-register memory transfer one word at a time. A command names one of four transfer kinds, an 8-bit list of low registers (indices 0 to 7), an optional extra slot, a base register index and the current base value. The block then walks the listed registers in the order that transfer kind requires. For each slot it issues one 32-bit memory access, reads or writes the register file, and advances a running address. Stack transfers use the stack pointer (register index 13). The extra slot stores the link register (index 14) on a push. On a pop it loads a new program counter, which the block reports as a branch request and does not write to the register file.

The memory side is a valid/ready request port. `mem_req_valid` stays high, with address, direction and write data steady, until `mem_req_ready` is seen high on a rising edge. That edge completes the access, and for loads `mem_rdata` is taken in the same cycle. The memory may hold `mem_req_ready` low for any number of cycles. The command side is plain: a command is taken on an edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the block is idle. Register-file reads are combinational through `rf_rd_idx`/`rf_rd_data`. Register writes and base updates are one-cycle strobes that coincide with the accepted memory access.

Top module: `xfer_list_seq`

## Requirements
- R1: `cmd_ready` is 1 exactly while idle. No request is issued while idle. `done` is high for one cycle, in the cycle after the edge that accepts the final access.
- R2: Push (`cmd_op`=2'b00): if `cmd_extra` is 1, register 14 is stored first at base-4. Then the listed registers are stored from index 7 down to 0, each at an address 4 below the previous access. Register 13 becomes base-4*N at the final access.
- R3: Pop (`cmd_op`=2'b01): the listed registers are loaded from index 0 up to 7. The first load comes from the base address and each later one from 4 above the previous. Register 13 becomes base+4*N at the final access.
- R4: On a pop with `cmd_extra`=1, one more word is loaded after all listed registers. It is not written to the register file: it appears on `branch_target` with bit 0 cleared, with a single-cycle `branch_valid`.
- R5: Store-multiple (`cmd_op`=2'b10) and load-multiple (`cmd_op`=2'b11) visit listed registers from 0 upward. The k-th access (k from 0) goes to base+4k with address bits 1:0 forced to zero.
- R6: Load-multiple writes base+4*N to the base register at the final access only when the base register is not in the list. Otherwise the base keeps the loaded word.
- R7: Store-multiple writes base+4*(k+1) to the base register with each k-th access. A listed base register is therefore stored with its value at that moment.
- R8: A command with an empty list and no effective extra slot makes no memory access and no register write, and raises `done` in the cycle after acceptance.
- R9: While a request waits for `mem_req_ready`, `mem_req_valid`, `mem_addr` and `mem_we` stay unchanged.
- R10: `cmd_extra` has no effect on store-multiple and load-multiple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 00 push, 01 pop, 10 store-multiple, 11 load-multiple |
| cmd_list | input | 8 | Low-register bitmap |
| cmd_extra | input | 1 | Link-register slot (push) or program-counter slot (pop) |
| cmd_base_idx | input | 3 | Base register for store/load-multiple |
| cmd_base_val | input | 32 | Current base or stack-pointer value |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request this edge |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_req_ready` |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| base_we | output | 1 | Base/stack-pointer write strobe |
| base_idx | output | 4 | Base register index (13 for stack transfers) |
| base_val | output | 32 | New base value |
| branch_valid | output | 1 | Program counter loaded |
| branch_target | output | 32 | Loaded program counter, bit 0 clear |
| done | output | 1 | Command finished pulse |

## Verification
The bench targets the ordering corners. A link-register slot placed after the low registers, or a pop walked high to low, would put words at swapped addresses. An odd program-counter word is loaded on pop: a design that leaks it into the register file, or that keeps bit 0, shows a wrong register or target. A store-multiple lists its own base both first and in the middle of the list, and a load-multiple lists its own base; a design that stores stale base values or writes back over the loaded base fails the register compare. Unaligned bases, empty lists and random memory stalls expose missing alignment, spurious accesses, and an address that moves while the memory is not ready.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_STM  = 2'b10,
    OP_LDM  = 2'b11
  } xop_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xst_e;

  localparam int unsigned SP_REG = 13;
  localparam int unsigned LR_REG = 14;
  localparam int unsigned PC_REG = 15;

endpackage

// File: rtl/xfer_pick.sv
module xfer_pick #(
  parameter int LIST_W = 8,
  localparam int IW = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] remain,
  input  logic              descend,
  output logic              any,
  output logic [IW-1:0]     idx,
  output logic [LIST_W-1:0] rest
);

  logic [LIST_W-1:0] flip;
  logic [LIST_W-1:0] src;
  logic [LIST_W-1:0] iso;
  logic [LIST_W-1:0] sel;

  // Descending order reuses the lowest-bit isolator on a mirrored list.
  for (genvar g = 0; g < LIST_W; g++) begin : g_mirror
    assign flip[g] = remain[LIST_W-1-g];
    assign sel[g]  = descend ? iso[LIST_W-1-g] : iso[g];
  end

  assign src  = descend ? flip : remain;
  assign iso  = src & (~src + 1'b1);
  assign any  = |remain;
  assign rest = remain & ~sel;

  always_comb begin
    idx = '0;
    for (int i = 0; i < LIST_W; i++) begin
      if (sel[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/xfer_addr.sv
module xfer_addr
  import xfer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  xop_e              op,
  input  logic [DATA_W-1:0] cur,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] nxt
);

  localparam int AL = $clog2(WORD_BYTES);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

  logic [DATA_W-1:0] dec;
  logic [DATA_W-1:0] inc;

  assign dec = cur - STEP;
  assign inc = cur + STEP;

  always_comb begin
    unique case (op)
      OP_PUSH: begin acc = dec; nxt = dec; end
      OP_POP:  begin acc = cur; nxt = inc; end
      default: begin
        acc = {cur[DATA_W-1:AL], {AL{1'b0}}};
        nxt = inc;
      end
    endcase
  end

endmodule

// File: rtl/xfer_wb.sv
module xfer_wb
  import xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  xop_e              op,
  input  logic              slot_pc,
  input  logic              slot_last,
  input  logic              base_in_list,
  input  logic [RIDX_W-1:0] slot_idx,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] nxt,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              base_we,
  output logic [DATA_W-1:0] base_val,
  output logic              branch_valid,
  output logic [DATA_W-1:0] branch_target
);

  logic is_load;
  logic final_wb;

  assign is_load    = (op == OP_POP) || (op == OP_LDM);
  assign rf_we      = ack && is_load && !slot_pc;
  assign rf_wr_idx  = slot_idx;
  assign rf_wr_data = rdata;

  assign branch_valid  = ack && slot_pc;
  assign branch_target = {rdata[DATA_W-1:1], 1'b0};

  // Stack transfers always update the pointer; load-multiple only if base not reloaded.
  assign final_wb = (op == OP_PUSH) || (op == OP_POP) || ((op == OP_LDM) && !base_in_list);
  assign base_we  = ack && ((op == OP_STM) || (slot_last && final_wb));
  assign base_val = nxt;

  // R6: a reloaded base is never overwritten by the writeback in the same cycle
  a_r6_no_wb_clash: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && base_we |-> rf_wr_idx != base_idx);

  // R4: the program-counter slot is always the final access of a command
  a_r4_pc_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid |-> slot_last && !rf_we);

endmodule

// File: rtl/xfer_list_seq.sv
module xfer_list_seq
  import xfer_pkg::*;
#(
  parameter int LIST_W     = 8,
  parameter int DATA_W     = 32,
  parameter int RIDX_W     = 4,
  parameter int WORD_BYTES = 4,
  localparam int LW_IDX    = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [LIST_W-1:0] cmd_list,
  input  logic              cmd_extra,
  input  logic [LW_IDX-1:0] cmd_base_idx,
  input  logic [DATA_W-1:0] cmd_base_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [RIDX_W-1:0] rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              base_we,
  output logic [RIDX_W-1:0] base_idx,
  output logic [DATA_W-1:0] base_val,
  output logic              branch_valid,
  output logic [DATA_W-1:0] branch_target,
  output logic              done
);

  localparam int AL = $clog2(WORD_BYTES);
  localparam logic [RIDX_W-1:0] SP_I = RIDX_W'(SP_REG);
  localparam logic [RIDX_W-1:0] LR_I = RIDX_W'(LR_REG);
  localparam logic [RIDX_W-1:0] PC_I = RIDX_W'(PC_REG);

  xst_e              st_q;
  xop_e              op_q;
  logic [LIST_W-1:0] remain_q;
  logic              extra_q;
  logic [DATA_W-1:0] cur_q;
  logic [RIDX_W-1:0] bidx_q;
  logic              bil_q;
  logic              done_q;

  // Command decode
  xop_e op_in;
  logic stack_in;
  logic ext_in;
  logic empty_in;
  logic fire;

  assign op_in    = xop_e'(cmd_op);
  assign stack_in = (op_in == OP_PUSH) || (op_in == OP_POP);
  assign ext_in   = cmd_extra && stack_in;
  assign empty_in = (cmd_list == '0) && !ext_in;
  assign fire     = cmd_valid && (st_q == ST_IDLE);

  // Slot selection
  logic              any;
  logic [LW_IDX-1:0] pick_idx;
  logic [LIST_W-1:0] rest;
  logic              slot_lr;
  logic              slot_pc;
  logic              slot_last;
  logic [RIDX_W-1:0] slot_idx;

  xfer_pick #(.LIST_W(LIST_W)) u_pick (
    .remain  (remain_q),
    .descend (op_q == OP_PUSH),
    .any     (any),
    .idx     (pick_idx),
    .rest    (rest)
  );

  assign slot_lr = (op_q == OP_PUSH) && extra_q;
  assign slot_pc = (op_q == OP_POP) && extra_q && !any;

  always_comb begin
    if (slot_lr)      slot_idx = LR_I;
    else if (slot_pc) slot_idx = PC_I;
    else              slot_idx = {{(RIDX_W-LW_IDX){1'b0}}, pick_idx};
  end

  always_comb begin
    if (slot_lr)      slot_last = !any;
    else if (slot_pc) slot_last = 1'b1;
    else              slot_last = (rest == '0) && !((op_q == OP_POP) && extra_q);
  end

  // Addressing
  logic [DATA_W-1:0] acc_addr;
  logic [DATA_W-1:0] nxt_addr;

  xfer_addr #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_addr (
    .op  (op_q),
    .cur (cur_q),
    .acc (acc_addr),
    .nxt (nxt_addr)
  );

  logic running;
  logic ack;

  assign running       = (st_q == ST_RUN);
  assign ack           = running && mem_req_ready;
  assign cmd_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = running;
  assign mem_we        = (op_q == OP_PUSH) || (op_q == OP_STM);
  assign mem_addr      = acc_addr;
  assign mem_wdata     = rf_rd_data;
  assign rf_rd_idx     = slot_idx;
  assign base_idx      = bidx_q;
  assign done          = done_q;

  xfer_wb #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_wb (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack           (ack),
    .op            (op_q),
    .slot_pc       (slot_pc),
    .slot_last     (slot_last),
    .base_in_list  (bil_q),
    .slot_idx      (slot_idx),
    .base_idx      (bidx_q),
    .rdata         (mem_rdata),
    .nxt           (nxt_addr),
    .rf_we         (rf_we),
    .rf_wr_idx     (rf_wr_idx),
    .rf_wr_data    (rf_wr_data),
    .base_we       (base_we),
    .base_val      (base_val),
    .branch_valid  (branch_valid),
    .branch_target (branch_target)
  );

  // Sequencer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_PUSH;
      remain_q <= '0;
      extra_q  <= 1'b0;
      cur_q    <= '0;
      bidx_q   <= '0;
      bil_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (fire) begin
          op_q     <= op_in;
          remain_q <= cmd_list;
          extra_q  <= ext_in;
          cur_q    <= cmd_base_val;
          bidx_q   <= stack_in ? SP_I : {{(RIDX_W-LW_IDX){1'b0}}, cmd_base_idx};
          bil_q    <= (op_in == OP_LDM) && cmd_list[cmd_base_idx];
          if (empty_in) done_q <= 1'b1;
          else          st_q   <= ST_RUN;
        end
      end else if (ack) begin
        cur_q <= nxt_addr;
        if (slot_lr || slot_pc) extra_q  <= 1'b0;
        else                    remain_q <= rest;
        if (slot_last) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R1: the memory port is quiet while idle
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid);

  // R1: completion is reported while idle
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R9: a stalled request keeps its address and direction
  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we));

  // R5: multiple transfers use word-aligned addresses
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (op_q == OP_STM || op_q == OP_LDM) |-> mem_addr[AL-1:0] == '0);

  // R8: an empty command completes next cycle with no access
  a_r8_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_list == '0) && !(cmd_extra && !cmd_op[1])
      |=> done && !mem_req_valid);

endmodule

// File: tb/xfer_list_seq_tb.sv
module xfer_list_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  cmd_list = 8'h00;
  logic        cmd_extra = 1'b0;
  logic [2:0]  cmd_base_idx = 3'd0;
  logic [31:0] cmd_base_val = 32'h0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        rf_we;
  logic [3:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic        base_we;
  logic [3:0]  base_idx;
  logic [31:0] base_val;
  logic        branch_valid;
  logic [31:0] branch_target;
  logic        done;

  always #5 clk = ~clk;

  xfer_list_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_list(cmd_list), .cmd_extra(cmd_extra),
    .cmd_base_idx(cmd_base_idx), .cmd_base_val(cmd_base_val),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .base_we(base_we),
    .base_idx(base_idx), .base_val(base_val), .branch_valid(branch_valid),
    .branch_target(branch_target), .done(done)
  );

  // Bench models of the register file and a 64-word memory
  logic [31:0] rf  [16];
  logic [31:0] mem [64];
  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_rdata  = mem[mem_addr[7:2]];

  // Expectations written by the stimulus thread
  logic [31:0] exp_addr [10];
  logic        exp_we   [10];
  logic [31:0] exp_wd   [10];
  logic [31:0] exp_rf   [16];
  int          exp_n = 0;
  int          acc_base = 0;
  string       cur_tag = "R1";
  int          seed_req = 0;
  int          seed_idx = 0;
  logic [31:0] seed_val = 0;

  // Monitor-owned state
  int          acc_cnt = 0, done_cnt = 0, br_cnt = 0, seed_ack = 0;
  logic [31:0] br_val = 0;
  logic        expect_done = 1'b0;
  logic        stall_prev = 1'b0;
  logic [31:0] stall_addr = 0;
  int          m_checks = 0, m_errors = 0;
  int          checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic mchk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    m_checks++;
    if (act !== expv) begin
      m_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Memory back-pressure, driven well away from the edges
  always @(posedge clk) begin
    #2;
    mem_req_ready = rst_n ? (($urandom % 4) != 0) : 1'b0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0001 + i * 32'h0011_0102;
      for (int j = 0; j < 64; j++) mem[j] = 32'hC0DE_0000 + j * 32'h0000_0105;
    end else begin
      if (expect_done) begin
        mchk("R1", {31'b0, done}, 32'd1);
        expect_done = 1'b0;
      end else if (done) begin
        mchk("R1 spurious done", 32'd1, 32'd0);
      end
      if (done) done_cnt++;
      if (stall_prev) begin
        mchk("R9", {31'b0, mem_req_valid}, 32'd1);
        mchk("R9", mem_addr, stall_addr);
      end
      if (branch_valid) begin
        br_cnt++;
        br_val = branch_target;
      end
      if (mem_req_valid && mem_req_ready) begin
        int k;
        k = acc_cnt - acc_base;
        if (k < exp_n) begin
          mchk(cur_tag, mem_addr, exp_addr[k]);
          mchk(cur_tag, {31'b0, mem_we}, {31'b0, exp_we[k]});
          if (exp_we[k]) mchk(cur_tag, mem_wdata, exp_wd[k]);
        end else begin
          mchk({cur_tag, " extra access"}, mem_addr, 32'hFFFF_FFFF);
        end
        if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
        acc_cnt++;
        if (k + 1 == exp_n) expect_done = 1'b1;
      end
      if (rf_we)   rf[rf_wr_idx] = rf_wr_data;
      if (base_we) rf[base_idx]  = base_val;
      if (cmd_valid && cmd_ready && cmd_list == 8'h00 && !(cmd_extra && !cmd_op[1]))
        expect_done = 1'b1;
      if (seed_req != seed_ack) begin
        rf[seed_idx] = seed_val;
        seed_ack = seed_req;
      end
      stall_prev = mem_req_valid && !mem_req_ready;
      stall_addr = mem_addr;
    end
  end

  task automatic add_exp(input logic [31:0] a, input logic we, input logic [31:0] wd);
    exp_addr[exp_n] = a;
    exp_we[exp_n]   = we;
    exp_wd[exp_n]   = wd;
    exp_n++;
  endtask

  // op: 0 push, 1 pop, 2 store-multiple, 3 load-multiple
  task automatic run_cmd(input string tag, input logic [1:0] op, input logic [7:0] list,
                         input logic ext, input logic [2:0] bi, input logic [31:0] bv);
    logic [31:0] a;
    logic [31:0] exp_br;
    int exp_brn, done_base, br_base, ridx;
    bit seen;
    ridx = (op < 2) ? 13 : int'(bi);
    @(posedge clk); #1;
    seed_idx = ridx; seed_val = bv; seed_req++;
    @(negedge clk); #1;
    for (int i = 0; i < 16; i++) exp_rf[i] = rf[i];
    exp_n = 0; exp_brn = 0; exp_br = 0; a = bv;
    case (op)
      2'd0: begin
        if (ext) begin a -= 4; add_exp(a, 1'b1, rf[14]); end
        for (int i = 7; i >= 0; i--) if (list[i]) begin a -= 4; add_exp(a, 1'b1, rf[i]); end
        exp_rf[13] = a;
      end
      2'd1: begin
        for (int i = 0; i < 8; i++) if (list[i]) begin
          add_exp(a, 1'b0, 0); exp_rf[i] = mem[a[7:2]]; a += 4;
        end
        if (ext) begin
          add_exp(a, 1'b0, 0); exp_br = mem[a[7:2]] & 32'hFFFF_FFFE; exp_brn = 1; a += 4;
        end
        exp_rf[13] = a;
      end
      2'd2: begin
        for (int i = 0; i < 8; i++) if (list[i]) begin
          add_exp({a[31:2], 2'b00}, 1'b1, (i == int'(bi)) ? a : rf[i]); a += 4;
        end
        exp_rf[bi] = a;
      end
      default: begin
        for (int i = 0; i < 8; i++) if (list[i]) begin
          add_exp({a[31:2], 2'b00}, 1'b0, 0); exp_rf[i] = mem[a[5'd7:2]]; a += 4;
        end
        if (!list[bi]) exp_rf[bi] = a;
      end
    endcase
    cur_tag = tag; acc_base = acc_cnt; done_base = done_cnt; br_base = br_cnt;
    @(posedge clk); #1;
    chk("R1", {31'b0, cmd_ready}, 32'd1);
    cmd_op = op; cmd_list = list; cmd_extra = ext; cmd_base_idx = bi; cmd_base_val = bv;
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    seen = 0;
    for (int t = 0; t < 400 && !seen; t++) begin
      @(negedge clk);
      if (done_cnt != done_base) seen = 1;
    end
    chk({tag, " done seen"}, {31'b0, seen}, 32'd1);
    @(negedge clk); #1;
    chk({tag, " access count"}, acc_cnt - acc_base, exp_n);
    for (int i = 0; i < 16; i++) chk({tag, " regfile"}, rf[i], exp_rf[i]);
    chk("R4 branch count", br_cnt - br_base, exp_brn);
    if (exp_brn != 0) chk("R4 branch target", br_val, exp_br);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + m_errors + 1, checks + m_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset ready", {31'b0, cmd_ready}, 32'd1);
    chk("R1 reset no req", {31'b0, mem_req_valid}, 32'd0);
    chk("R1 reset done", {31'b0, done}, 32'd0);

    run_cmd("R2 push lr", 2'd0, 8'h81, 1'b1, 3'd0, 32'h0000_0080);
    run_cmd("R4 pop pc",  2'd1, 8'h81, 1'b1, 3'd0, 32'h0000_0074);
    run_cmd("R3 pop",     2'd1, 8'h3C, 1'b0, 3'd0, 32'h0000_0090);
    run_cmd("R7 stm base mid",   2'd2, 8'h0F, 1'b0, 3'd2, 32'h0000_0050);
    run_cmd("R7 stm base first", 2'd2, 8'h05, 1'b0, 3'd0, 32'h0000_00A3);
    run_cmd("R6 ldm base listed", 2'd3, 8'h18, 1'b0, 3'd3, 32'h0000_0062);
    run_cmd("R5 ldm unaligned",   2'd3, 8'hC0, 1'b0, 3'd1, 32'h0000_0071);
    run_cmd("R8 empty push", 2'd0, 8'h00, 1'b0, 3'd0, 32'h0000_0088);
    run_cmd("R8 empty ldm",  2'd3, 8'h00, 1'b1, 3'd4, 32'h0000_0060);
    run_cmd("R4 pop pc only", 2'd1, 8'h00, 1'b1, 3'd0, 32'h0000_0058);
    run_cmd("R10 ldm extra ignored", 2'd3, 8'h06, 1'b1, 3'd0, 32'h0000_0044);
    run_cmd("R10 stm extra ignored", 2'd2, 8'h90, 1'b1, 3'd5, 32'h0000_0048);
    run_cmd("R2 push lr only", 2'd0, 8'h00, 1'b1, 3'd0, 32'h0000_00B0);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] op;
      logic [7:0] list;
      logic [31:0] bv;
      op   = 2'($urandom % 4);
      list = (($urandom % 8) == 0) ? 8'h00 : 8'($urandom);
      bv   = 32'h40 + ($urandom % 32) * 4 + ((op >= 2) ? ($urandom % 4) : 0);
      case (op)
        2'd0: run_cmd("R2 rand push", op, list, 1'($urandom), 3'($urandom), bv);
        2'd1: run_cmd("R3 rand pop",  op, list, 1'($urandom), 3'($urandom), bv);
        2'd2: run_cmd("R7 rand stm",  op, list, 1'($urandom), 3'($urandom), bv);
        default: run_cmd("R6 rand ldm", op, list, 1'($urandom), 3'($urandom), bv);
      endcase
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors + m_errors, checks + m_checks);
    $finish;
  end

endmodule